// File: doc/BRIEF.md
# Trigger-Configurable Two-Output Interrupt Router

This block collects 32 asynchronous interrupt inputs and steers each of them to one of two request outputs. Software sets up every source through bit-wise set and clear addresses. A write of 1 to a bit at a set address turns that bit on, and a write of 1 at a clear address turns it off. Bits written as 0 keep their value. A three-bit trigger mode per source selects one of these behaviours:

- edge capture on a rising edge
- edge capture on a falling edge
- edge capture on both edges
- level sensing of a high input
- level sensing of a low input

Captured edges sit in two sticky words, one for rising edges and one for falling edges. Software acknowledges them by writing 1 to the matching capture clear address.

A per-source enable gates each request. A per-source route bit picks the output line. A separate wake-enable word decides which sources can raise the wake output. The pending word of each output can be read back. Each request output is high whenever its pending word is non-zero.

Top module: `intc_router`

## Requirements
- R1: After reset every readable word is 0 and `irq_req0`, `irq_req1` and `wake_out` are 0.
- R2: Address encoding is as follows. `wr_addr[5:4]` is the operation: 1 means set and 2 means clear. 0 and 3 mean no operation. `wr_addr[3:0]` is the register index. Indices 0 to 7 are the control words: trigger bit0, trigger bit1, trigger bit2, source select, route, wake enable, enable and test. A write with wr_en=1 changes only the bits where wr_data is 1, and the new value reads back on `rd_addr` (a combinational read) in the cycle that follows the write edge.
- R3: The trigger mode of source n is {bit2[n], bit1[n], bit0[n]}. Mode 001 captures rising edges into the rising word (index 8). After an input change, the captured bit appears after the third rising clock edge and not before.
- R4: Mode 010 captures only falling edges into the falling word (index 9). Mode 011 captures both kinds of edge. An edge of a kind that the mode does not select is never recorded.
- R5: Mode 101 makes a source pending while its synchronized input is 1. Mode 110 makes it pending while the input is 0. Each takes effect two clock edges after the input changes, and nothing is latched. Modes 000, 100 and 111 never make a source pending.
- R6: Writing 1 at the clear address of a capture word (operation 2, index 8 or 9) clears those bits. A set operation aimed at a capture word or a pending word (index 10 or 11) has no effect.
- R7: A source drives a request only while its enable bit is 1. Clearing the enable bit keeps its captured edges, so the request returns when the source is enabled again.
- R8: A route bit of 1 sends the source to `irq_req0`, and a route bit of 0 sends it to `irq_req1`. The pending words read at index 10 (request 0) and index 11 (request 1) hold bit n when source n is pending, enabled and routed to that output. Each request output is the OR of its word.
- R9: `wake_out` is 1 whenever any pending source has its wake-enable bit (index 5) set, independent of the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | {operation[1:0], register index[3:0]} |
| wr_data | input | 32 | Bit mask for set or clear |
| rd_addr | input | 4 | Register index to read |
| rd_data | output | 32 | Combinational read data |
| irq_in | input | 32 | Asynchronous interrupt inputs |
| irq_req0 | output | 1 | Request output 0 |
| irq_req1 | output | 1 | Request output 1 |
| wake_out | output | 1 | Wake output |

## Verification
A register write is visible on the read port in the first cycle after its write edge. A level input reaches its pending bit and the request outputs two edges after it changes. An edge input lands in its capture word three edges after it changes. The bench drives every stimulus just after a falling edge and waits exactly that many rising edges before it samples at the next falling edge. For the capture path it also samples one edge early, to show that the capture bit is still 0 at that point. Expected words are queued by the driver, and a monitor pops each one a fraction of a cycle later and compares it with the port value.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int IDX_W = 4;
  localparam int OP_W  = 2;
  localparam int N_CTRL = 8;

  typedef enum logic [OP_W-1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSV  = 2'd3
  } wr_op_e;

  typedef enum logic [IDX_W-1:0] {
    RG_TRIG0 = 4'd0,
    RG_TRIG1 = 4'd1,
    RG_TRIG2 = 4'd2,
    RG_SRCSEL = 4'd3,
    RG_ROUTE = 4'd4,
    RG_WAKE  = 4'd5,
    RG_ENA   = 4'd6,
    RG_TEST  = 4'd7,
    RG_RCAP  = 4'd8,
    RG_FCAP  = 4'd9,
    RG_PEND0 = 4'd10,
    RG_PEND1 = 4'd11
  } reg_idx_e;

  function automatic logic mode_rise(input logic [2:0] m);
    return (m == 3'b001) || (m == 3'b011);
  endfunction

  function automatic logic mode_fall(input logic [2:0] m);
    return (m == 3'b010) || (m == 3'b011);
  endfunction

  function automatic logic mode_high(input logic [2:0] m);
    return m == 3'b101;
  endfunction

  function automatic logic mode_low(input logic [2:0] m);
    return m == 3'b110;
  endfunction
endpackage

// File: rtl/intc_setclr_reg.sv
module intc_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb q_next = (q & ~clr_v) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((q & $past(set_v)) == $past(set_v)));

  assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|clr_v) && !(|set_v)) |=> ((q & $past(clr_v)) == '0));
endmodule

// File: rtl/intc_src_unit.sv
module intc_src_unit
  import intc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] trig0,
  input  logic [N_SRC-1:0] trig1,
  input  logic [N_SRC-1:0] trig2,
  input  logic [N_SRC-1:0] rcap_clr,
  input  logic [N_SRC-1:0] fcap_clr,
  output logic [N_SRC-1:0] rise_cap,
  output logic [N_SRC-1:0] fall_cap,
  output logic [N_SRC-1:0] raw_pend
);
  logic [N_SRC-1:0] sync_q [SYNC_STAGES];
  logic [N_SRC-1:0] s_now, s_prev;
  logic [N_SRC-1:0] sel_r, sel_f, sel_h, sel_l;
  logic [N_SRC-1:0] rise_hit, fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= irq_in;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[k] <= '0;
      else        sync_q[k] <= sync_q[k-1];
    end
  end

  assign s_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= '0;
    else        s_prev <= s_now;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_mode
    logic [2:0] m;
    assign m        = {trig2[i], trig1[i], trig0[i]};
    assign sel_r[i] = mode_rise(m);
    assign sel_f[i] = mode_fall(m);
    assign sel_h[i] = mode_high(m);
    assign sel_l[i] = mode_low(m);
    always_comb begin
      if (sel_r[i] || sel_f[i]) raw_pend[i] = rise_cap[i] | fall_cap[i];
      else if (sel_h[i])        raw_pend[i] = s_now[i];
      else if (sel_l[i])        raw_pend[i] = ~s_now[i];
      else                      raw_pend[i] = 1'b0;
    end
  end

  assign rise_hit = s_now & ~s_prev & sel_r;
  assign fall_hit = ~s_now & s_prev & sel_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cap <= '0;
      fall_cap <= '0;
    end else begin
      rise_cap <= (rise_cap & ~rcap_clr) | rise_hit;
      fall_cap <= (fall_cap & ~fcap_clr) | fall_hit;
    end
  end

  assert_rise_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_hit) |=> ((rise_cap & $past(rise_hit)) == $past(rise_hit)));

  assert_fall_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|fall_hit) |=> ((fall_cap & $past(fall_hit)) == $past(fall_hit)));

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rise_cap & ~$past(rise_cap) & ~$past(rise_hit)) == '0) &&
              ((fall_cap & ~$past(fall_cap) & ~$past(fall_hit)) == '0)));
endmodule

// File: rtl/intc_router.sv
module intc_router
  import intc_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [OP_W+IDX_W-1:0] wr_addr,
  input  logic [N_SRC-1:0]      wr_data,
  input  logic [IDX_W-1:0]      rd_addr,
  output logic [N_SRC-1:0]      rd_data,
  input  logic [N_SRC-1:0]      irq_in,
  output logic                  irq_req0,
  output logic                  irq_req1,
  output logic                  wake_out
);
  wr_op_e           op;
  logic [IDX_W-1:0] widx;
  logic [N_SRC-1:0] ctrl_q [N_CTRL];
  logic [N_SRC-1:0] ctrl_set [N_CTRL];
  logic [N_SRC-1:0] ctrl_clr [N_CTRL];
  logic [N_SRC-1:0] rcap_clr, fcap_clr;
  logic [N_SRC-1:0] rise_cap, fall_cap, raw_pend;
  logic [N_SRC-1:0] pend0_w, pend1_w;
  logic [N_SRC-1:0] route_q, ena_q, wake_q;

  assign op   = wr_op_e'(wr_addr[OP_W+IDX_W-1:IDX_W]);
  assign widx = wr_addr[IDX_W-1:0];

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    assign ctrl_set[g] = (wr_en && op == OP_SET && widx == IDX_W'(g)) ? wr_data : '0;
    assign ctrl_clr[g] = (wr_en && op == OP_CLR && widx == IDX_W'(g)) ? wr_data : '0;
    intc_setclr_reg #(.W(N_SRC)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_v (ctrl_set[g]),
      .clr_v (ctrl_clr[g]),
      .q     (ctrl_q[g])
    );
  end

  assign rcap_clr = (wr_en && op == OP_CLR && widx == RG_RCAP) ? wr_data : '0;
  assign fcap_clr = (wr_en && op == OP_CLR && widx == RG_FCAP) ? wr_data : '0;

  intc_src_unit #(.N_SRC(N_SRC), .SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .trig0    (ctrl_q[RG_TRIG0]),
    .trig1    (ctrl_q[RG_TRIG1]),
    .trig2    (ctrl_q[RG_TRIG2]),
    .rcap_clr (rcap_clr),
    .fcap_clr (fcap_clr),
    .rise_cap (rise_cap),
    .fall_cap (fall_cap),
    .raw_pend (raw_pend)
  );

  assign route_q = ctrl_q[RG_ROUTE];
  assign ena_q   = ctrl_q[RG_ENA];
  assign wake_q  = ctrl_q[RG_WAKE];

  assign pend0_w  = raw_pend & ena_q & route_q;
  assign pend1_w  = raw_pend & ena_q & ~route_q;
  assign irq_req0 = |pend0_w;
  assign irq_req1 = |pend1_w;
  assign wake_out = |(raw_pend & wake_q);

  always_comb begin
    rd_data = '0;
    if (rd_addr < IDX_W'(N_CTRL)) rd_data = ctrl_q[rd_addr[2:0]];
    else if (rd_addr == RG_RCAP)  rd_data = rise_cap;
    else if (rd_addr == RG_FCAP)  rd_data = fall_cap;
    else if (rd_addr == RG_PEND0) rd_data = pend0_w;
    else if (rd_addr == RG_PEND1) rd_data = pend1_w;
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!irq_req0 && !irq_req1 && !wake_out));

  assert_ena_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ctrl_clr[RG_ENA]) && !(|rcap_clr))
      |=> ((rise_cap & $past(rise_cap)) == $past(rise_cap)));

  assert_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req0 |-> (|(route_q & ena_q)));

  assert_route1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req1 |-> (|(~route_q & ena_q)));
endmodule

// File: tb/sim_intc_router.sv
`timescale 1ns/100ps
module sim_intc_router;
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] irq_in = '0;
  logic        irq_req0, irq_req1, wake_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t q[$];
  event sample_ev;

  localparam logic [1:0] SET = 2'd1, CLR = 2'd2;
  localparam int K_RD = 0, K_R0 = 1, K_R1 = 2, K_WK = 3;

  always #5 clk = ~clk;

  intc_router u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_in(irq_in), .irq_req0(irq_req0), .irq_req1(irq_req1),
    .wake_out(wake_out)
  );

  task automatic wr(input logic [1:0] o, input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {o, idx}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int kind, input logic [3:0] idx, input logic [31:0] exp, input string tag);
    item_t it;
    rd_addr = idx;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      #0.5;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RD:    act = rd_data;
          K_R0:    act = {31'b0, irq_req0};
          K_R1:    act = {31'b0, irq_req1};
          default: act = {31'b0, wake_out};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    // R1 reset state
    chk(K_RD, 0, 0, "R1 trig0");
    chk(K_RD, 6, 0, "R1 enable");
    chk(K_RD, 10, 0, "R1 pend0");
    chk(K_R0, 0, 0, "R1 req0");
    chk(K_R1, 0, 0, "R1 req1");
    chk(K_WK, 0, 0, "R1 wake");
    // R2 set/clear semantics
    wr(SET, 0, 32'hF0);  chk(K_RD, 0, 32'hF0, "R2 set");
    wr(SET, 0, 32'h0F);  chk(K_RD, 0, 32'hFF, "R2 set merge");
    wr(CLR, 0, 32'h30);  chk(K_RD, 0, 32'hCF, "R2 clear");
    wr(SET, 0, 32'h0);   chk(K_RD, 0, 32'hCF, "R2 zero write");
    wr(CLR, 0, 32'hFFFFFFFF); chk(K_RD, 0, 0, "R2 clear all");
    wr(SET, 7, 32'hA5);  chk(K_RD, 7, 32'hA5, "R2 test word");
    wr(CLR, 7, 32'hFFFFFFFF); chk(K_RD, 7, 0, "R2 test clear");
    // R3 rising edge, source 0 routed to req0
    wr(SET, 6, 32'h1); wr(SET, 4, 32'h1); wr(SET, 0, 32'h1);
    drive(32'h1);
    cycles(2); chk(K_RD, 8, 0, "R3 not yet captured");
    cycles(1); chk(K_RD, 8, 32'h1, "R3 captured");
    chk(K_R0, 0, 1, "R3 req0");
    chk(K_R1, 0, 0, "R8 req1 idle");
    drive(32'h0); cycles(4);
    chk(K_RD, 9, 0, "R4 fall ignored in rise mode");
    chk(K_R0, 0, 1, "R3 latched");
    wr(CLR, 8, 32'h1);
    chk(K_RD, 8, 0, "R6 rise ack");
    chk(K_R0, 0, 0, "R6 req0 drops");
    // R4 falling edge, source 1 routed to req1
    wr(SET, 6, 32'h2); wr(SET, 1, 32'h2);
    drive(32'h2); cycles(4);
    chk(K_RD, 8, 0, "R4 rise ignored in fall mode");
    chk(K_R1, 0, 0, "R4 no req on rise");
    drive(32'h0); cycles(3);
    chk(K_RD, 9, 32'h2, "R4 fall captured");
    chk(K_RD, 11, 32'h2, "R8 pend1 word");
    chk(K_R1, 0, 1, "R4 req1");
    wr(CLR, 9, 32'h2); chk(K_R1, 0, 0, "R6 fall ack");
    // R4 both edges, source 2
    wr(SET, 6, 32'h4); wr(SET, 4, 32'h4); wr(SET, 0, 32'h4); wr(SET, 1, 32'h4);
    drive(32'h4); cycles(3);
    chk(K_RD, 8, 32'h4, "R4 both rise");
    wr(CLR, 8, 32'h4);
    drive(32'h0); cycles(3);
    chk(K_RD, 9, 32'h4, "R4 both fall");
    chk(K_R0, 0, 1, "R4 both req0");
    wr(CLR, 9, 32'h4); chk(K_RD, 10, 0, "R6 pend0 clear");
    // R5 high level, source 3 to req1, plus R9 wake
    wr(SET, 6, 32'h8); wr(SET, 0, 32'h8); wr(SET, 2, 32'h8);
    drive(32'h8);
    cycles(1); chk(K_R1, 0, 0, "R5 high level latency");
    cycles(1); chk(K_R1, 0, 1, "R5 high level");
    chk(K_RD, 11, 32'h8, "R5 pend1");
    wr(SET, 5, 32'h8); chk(K_WK, 0, 1, "R9 wake set");
    drive(32'h0); cycles(2);
    chk(K_R1, 0, 0, "R5 no latch");
    chk(K_WK, 0, 0, "R9 wake follows");
    chk(K_RD, 8, 0, "R5 no capture");
    wr(CLR, 5, 32'h8);
    drive(32'h8); cycles(2);
    chk(K_WK, 0, 0, "R9 wake disabled");
    chk(K_R1, 0, 1, "R5 high again");
    drive(32'h0); cycles(2);
    wr(CLR, 0, 32'h8); wr(CLR, 2, 32'h8);
    // R5 low level, source 4 to req0
    wr(SET, 6, 32'h10); wr(SET, 4, 32'h10); wr(SET, 1, 32'h10); wr(SET, 2, 32'h10);
    chk(K_RD, 10, 32'h10, "R5 low level pend0");
    chk(K_R0, 0, 1, "R5 low level req0");
    drive(32'h10); cycles(2);
    chk(K_R0, 0, 0, "R5 low released");
    drive(32'h0); cycles(2);
    wr(CLR, 1, 32'h10); wr(CLR, 2, 32'h10);
    // R5 modes 100 and 111 stay silent, source 5
    wr(SET, 6, 32'h20); wr(SET, 2, 32'h20);
    drive(32'h20); cycles(3);
    chk(K_RD, 8, 0, "R5 mode100 no rise");
    chk(K_RD, 11, 0, "R5 mode100 no pend");
    drive(32'h0); cycles(3);
    chk(K_RD, 9, 0, "R5 mode100 no fall");
    wr(SET, 0, 32'h20); wr(SET, 1, 32'h20);
    drive(32'h20); cycles(3);
    chk(K_RD, 8, 0, "R5 mode111 no rise");
    chk(K_R1, 0, 0, "R5 mode111 no req");
    drive(32'h0); cycles(3);
    // R6 set to capture or pending address ignored
    wr(SET, 8, 32'hFFFFFFFF); chk(K_RD, 8, 0, "R6 set on rise word");
    wr(SET, 10, 32'hFFFFFFFF); chk(K_RD, 10, 0, "R6 set on pend word");
    // R7 enable gating, source 6
    wr(SET, 4, 32'h40); wr(SET, 0, 32'h40);
    drive(32'h40); cycles(3);
    chk(K_RD, 8, 32'h40, "R7 captured while disabled");
    chk(K_R0, 0, 0, "R7 gated");
    wr(SET, 6, 32'h40); chk(K_R0, 0, 1, "R7 enabled");
    wr(CLR, 6, 32'h40);
    chk(K_RD, 8, 32'h40, "R7 capture kept");
    chk(K_R0, 0, 0, "R7 gated again");
    // R8 routing of source 31
    wr(SET, 6, 32'h80000000); wr(SET, 0, 32'h80000000);
    drive(32'h80000040); cycles(3);
    chk(K_RD, 11, 32'h80000000, "R8 src31 on pend1");
    chk(K_R1, 0, 1, "R8 req1");
    chk(K_RD, 10, 0, "R8 pend0 empty");
    wr(SET, 4, 32'h80000000);
    chk(K_RD, 10, 32'h80000000, "R8 rerouted pend0");
    chk(K_RD, 11, 0, "R8 pend1 empty");
    chk(K_R0, 0, 1, "R8 req0");
    chk(K_R1, 0, 0, "R8 req1 off");
    cycles(2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule